// File: doc/BRIEF.md
# Integrating ADC Conversion Sequencer

This block sits on the digital side of an external single-slope integrating converter that has four analog inputs. It drives a 3-bit selector that tells the analog part what to integrate: nothing, a capacitor discharge, the zero-scale (ground) level, the reference level, or one of the four inputs. While a selection is integrating, the analog part holds a ready-high line (`int_in`). The block measures how long that line stays high by counting clock cycles.

A request names a channel. Before any conversion that lacks a valid calibration, the block measures the ground pulse and then the reference pulse. It keeps both counts and reuses them for later channel conversions until a programmable number of conversions has passed. Each input count is corrected for offset and gain against the cached pair. A bit-serial restoring divider then turns it into a fixed-point code. Each measurement is preceded by a programmable discharge hold. A programmable timeout aborts any measurement whose pulse never starts or never ends.

Top module: `iadc_seq`

## Requirements
- R1: The selector `mode` carries code 0 (idle) whenever the block is neither discharging nor measuring, and always while `busy` is low. Code 1 is discharge, code 2 is ground, code 3 is reference, and input channel k (0..3) is code 4+k.
- R2: Every measurement selection (code 2 or higher) is entered directly from discharge. The discharge has lasted at least max(1, `dis_cycles`) cycles.
- R3: A pulse count equals the number of rising clock edges at which `int_in` is sampled high after the selection starts. It saturates at 2^CNT_W-1 and never wraps.
- R4: When no valid calibration exists, a request measures ground first, then reference, then the requested input.
- R5: With counts G (ground), F (reference) and I (input), the result is 0 when I <= G and 2^RES_W-1 when I >= F. Otherwise it is floor((I-G)*2^RES_W/(F-G)).
- R6: A cached calibration is reused: no ground or reference selection occurs while the number of conversions since calibration is below `recal_every`. Changing the ground or reference pulse widths in that period has no effect on results.
- R7: Once `recal_every` conversions have completed since the last calibration, the next request recalibrates first. A value of 0 recalibrates on every request.
- R8: `result_valid` is a one-cycle pulse that carries `result` and the requested channel on `result_chan`. `busy` is low in that cycle.
- R9: If a measurement stays active for `timeout_cycles` cycles without completing, the block aborts it. `err` pulses for one cycle and no result is given. The block discharges, returns to idle and discards the calibration.
- R10: `start` is accepted only while `busy` is low. A `start` during a conversion neither restarts it nor changes its channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request |
| chan | input | 2 | Requested input channel |
| dis_cycles | input | DIS_W | Minimum discharge hold in cycles |
| timeout_cycles | input | TO_W | Measurement abort limit in cycles |
| recal_every | input | RCL_W | Conversions served by one calibration |
| int_in | input | 1 | Integrator ready-high line |
| mode | output | 3 | Analog selector code |
| busy | output | 1 | Conversion in progress |
| result | output | RES_W | Calibrated result code |
| result_chan | output | 2 | Channel of the current result |
| result_valid | output | 1 | Result strobe |
| err | output | 1 | Measurement timeout strobe |

## Verification
The bench builds the block with its defaults: 14-bit counts, 12-bit results and 16-bit discharge and timeout limits. These reach the saturation case of R3 in about 17,000 cycles of reference pulse, which shows saturation rather than wrap in the result. A model of the analog part raises `int_in` two cycles after each selection, with a width chosen per selection. This lets the bench set ground, reference and input counts apart and change them after calibration to show caching. Small discharge and timeout values keep the abort and recalibration cases short.

// File: rtl/iadc_seq_pkg.sv
package iadc_seq_pkg;
  typedef enum logic [2:0] {
    SEL_IDLE = 3'd0,
    SEL_DIS  = 3'd1,
    SEL_GND  = 3'd2,
    SEL_REF  = 3'd3,
    SEL_IN0  = 3'd4,
    SEL_IN1  = 3'd5,
    SEL_IN2  = 3'd6,
    SEL_IN3  = 3'd7
  } sel_e;

  typedef enum logic [1:0] {PH_GND, PH_REF, PH_IN} phase_e;

  typedef enum logic [2:0] {ST_IDLE, ST_DIS, ST_MEAS, ST_DIV, ST_ABORT} state_e;

  function automatic logic [2:0] input_code(input logic [1:0] ch);
    return {1'b1, ch};
  endfunction
endpackage

// File: rtl/iadc_pulse_meter.sv
module iadc_pulse_meter #(
  parameter int CNT_W = 14,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             int_in,
  input  logic [TO_W-1:0]  timeout_cycles,
  output logic             done,
  output logic             timed_out,
  output logic [CNT_W-1:0] count
);
  logic            seen_hi;
  logic [TO_W-1:0] timer;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      seen_hi <= 1'b0;
      count   <= '0;
      timer   <= '0;
    end else begin
      if (timer != '1) timer <= timer + 1'b1;
      if (int_in) begin
        seen_hi <= 1'b1;
        count   <= sat_inc(count);
      end
    end
  end

  assign done      = active && seen_hi && !int_in;
  assign timed_out = active && !done && (timer >= timeout_cycles);
endmodule

// File: rtl/iadc_divider.sv
module iadc_divider #(
  parameter int NUM_W = 14,
  parameter int Q_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [NUM_W-1:0] den,
  output logic             done,
  output logic [Q_W-1:0]   quo
);
  localparam int REM_W = NUM_W + 1;
  localparam int CW    = $clog2(Q_W + 1);

  logic [REM_W-1:0] rem;
  logic [CW-1:0]    left;
  logic [REM_W:0]   stp;

  // one restoring step: shift in a zero, subtract when it fits
  function automatic logic [REM_W:0] div_step(input logic [REM_W-1:0] r,
                                              input logic [NUM_W-1:0] d);
    logic [REM_W:0] sh;
    logic [REM_W:0] diff;
    sh   = {r, 1'b0};
    diff = sh - {2'b00, d};
    if (sh >= {2'b00, d}) return {diff[REM_W-1:0], 1'b1};
    return {sh[REM_W-1:0], 1'b0};
  endfunction

  assign stp = div_step(rem, den);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      left <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem  <= {1'b0, num};
        quo  <= '0;
        left <= CW'(Q_W);
      end else if (left != '0) begin
        rem  <= stp[REM_W:1];
        quo  <= {quo[Q_W-2:0], stp[0]};
        left <= left - 1'b1;
        done <= (left == CW'(1));
      end
    end
  end
endmodule

// File: rtl/iadc_seq.sv
module iadc_seq
  import iadc_seq_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int RES_W = 12,
  parameter int DIS_W = 16,
  parameter int TO_W  = 16,
  parameter int RCL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       chan,
  input  logic [DIS_W-1:0] dis_cycles,
  input  logic [TO_W-1:0]  timeout_cycles,
  input  logic [RCL_W-1:0] recal_every,
  input  logic             int_in,
  output logic [2:0]       mode,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic [1:0]       result_chan,
  output logic             result_valid,
  output logic             err
);
  localparam logic [RES_W-1:0] FULL = '1;

  state_e           st;
  phase_e           ph;
  logic [1:0]       ch;
  logic [DIS_W-1:0] dis_cnt;
  logic [CNT_W-1:0] tgnd, tref, tin;
  logic             cal_ok;
  logic [RCL_W-1:0] conv_cnt;

  // named internal events for the checker
  logic             meas_active, meas_done, meas_to, dis_exit, need_cal, div_go, div_done;
  logic [CNT_W-1:0] meas_count;
  logic [RES_W-1:0] quo;

  assign meas_active = (st == ST_MEAS);
  assign dis_exit    = ({1'b0, dis_cnt} + 1'b1) >= {1'b0, dis_cycles};
  assign need_cal    = !cal_ok || (conv_cnt >= recal_every);
  assign div_go      = meas_active && meas_done && (ph == PH_IN);
  assign busy        = (st != ST_IDLE);

  iadc_pulse_meter #(.CNT_W(CNT_W), .TO_W(TO_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .active(meas_active), .int_in(int_in),
    .timeout_cycles(timeout_cycles), .done(meas_done), .timed_out(meas_to),
    .count(meas_count)
  );

  iadc_divider #(.NUM_W(CNT_W), .Q_W(RES_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .num(meas_count - tgnd), .den(tref - tgnd),
    .done(div_done), .quo(quo)
  );

  always_comb begin
    case (st)
      ST_DIS, ST_ABORT: mode = SEL_DIS;
      ST_MEAS: begin
        case (ph)
          PH_GND:  mode = SEL_GND;
          PH_REF:  mode = SEL_REF;
          default: mode = input_code(ch);
        endcase
      end
      default: mode = SEL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_GND; ch <= '0; dis_cnt <= '0;
      tgnd <= '0; tref <= '0; tin <= '0; cal_ok <= 1'b0; conv_cnt <= '0;
      result <= '0; result_chan <= '0; result_valid <= 1'b0; err <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      err          <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          ch      <= chan;
          ph      <= need_cal ? PH_GND : PH_IN;
          dis_cnt <= '0;
          st      <= ST_DIS;
        end
        ST_DIS: begin
          if (dis_exit) st <= ST_MEAS;
          else dis_cnt <= dis_cnt + 1'b1;
        end
        ST_MEAS: begin
          if (meas_done) begin
            dis_cnt <= '0;
            case (ph)
              PH_GND: begin tgnd <= meas_count; ph <= PH_REF; st <= ST_DIS; end
              PH_REF: begin
                tref <= meas_count; cal_ok <= 1'b1; conv_cnt <= '0;
                ph <= PH_IN; st <= ST_DIS;
              end
              default: begin tin <= meas_count; st <= ST_DIV; end
            endcase
          end else if (meas_to) begin
            err     <= 1'b1;
            cal_ok  <= 1'b0;
            dis_cnt <= '0;
            st      <= ST_ABORT;
          end
        end
        ST_DIV: if (div_done) begin
          if (tin <= tgnd)      result <= '0;
          else if (tin >= tref) result <= FULL;
          else                  result <= quo;
          result_chan  <= ch;
          result_valid <= 1'b1;
          if (conv_cnt != '1) conv_cnt <= conv_cnt + 1'b1;
          st <= ST_IDLE;
        end
        ST_ABORT: begin
          if (dis_exit) st <= ST_IDLE;
          else dis_cnt <= dis_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iadc_seq_chk.sv
module iadc_seq_chk #(
  parameter int CNT_W = 14,
  parameter int DIS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode,
  input logic             busy,
  input logic             start,
  input logic             result_valid,
  input logic             err,
  input logic [DIS_W-1:0] dis_cycles,
  input logic             meas_active,
  input logic [CNT_W-1:0] meas_count
);
  logic [DIS_W:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (mode == 3'd1) run <= (run == '1) ? run : run + 1'b1;
    else run <= '0;
  end

  p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mode == 3'd0);

  p_dis_before_meas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd2 && $past(mode) != mode) |-> ($past(mode) == 3'd1 && run != '0 && run >= {1'b0, dis_cycles}));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(meas_active) && $past(meas_count) != '0) |-> meas_count >= $past(meas_count));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !busy);

  p_err_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !result_valid);

  p_start_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
endmodule

bind iadc_seq iadc_seq_chk #(.CNT_W(CNT_W), .DIS_W(DIS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .busy(busy), .start(start),
  .result_valid(result_valid), .err(err), .dis_cycles(dis_cycles),
  .meas_active(meas_active), .meas_count(meas_count)
);

// File: tb/iadc_seq_test.sv
module iadc_seq_test;
  localparam int CNT_W = 14;
  localparam int RES_W = 12;
  localparam int CMAX  = (1 << CNT_W) - 1;
  localparam int NV    = 8;
  // {channel, input pulse width}; ground 40, reference 1000
  localparam int VEC [NV][2] = '{'{0, 40}, '{1, 30}, '{2, 1000}, '{3, 1200},
                                 '{0, 520}, '{1, 41}, '{2, 999}, '{3, 300}};

  logic        clk = 0, rst_n = 0, start = 0, int_in = 0;
  logic [1:0]  chan = 0;
  logic [15:0] dis_cycles = 16'd20, timeout_cycles = 16'd3000;
  logic [7:0]  recal_every = 8'd100;
  logic [2:0]  mode;
  logic        busy, result_valid, err;
  logic [11:0] result;
  logic [1:0]  result_chan;

  int errors = 0, checks = 0, cycles = 0;
  int w_gnd = 40, w_ref = 1000;
  int w_in [4] = '{100, 100, 100, 100};
  bit dead = 0, stuck = 0;
  int mctr = 0, disrun = 0, dis_viol = 0, gnd_seen = 0;
  logic [2:0] prev_mode = 0, last_in = 0;
  logic [2:0] seq [3] = '{0, 0, 0};

  iadc_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .dis_cycles(dis_cycles),
    .timeout_cycles(timeout_cycles), .recal_every(recal_every), .int_in(int_in),
    .mode(mode), .busy(busy), .result(result), .result_chan(result_chan),
    .result_valid(result_valid), .err(err)
  );

  always #10 clk = ~clk;

  function automatic int width_of(input logic [2:0] m);
    if (m == 3'd2) return w_gnd;
    if (m == 3'd3) return w_ref;
    return w_in[m[1:0]];
  endfunction

  // analog model: pulse starts 2 cycles after a selection, driven on negedges
  always @(negedge clk) begin
    cycles++;
    if (mode >= 3'd2) begin
      if (mode != prev_mode) begin
        mctr = 0;
        if (prev_mode != 3'd1 || disrun < ((dis_cycles == 0) ? 1 : int'(dis_cycles))) dis_viol++;
        seq[0] = seq[1]; seq[1] = seq[2]; seq[2] = mode;
        if (mode == 3'd2) gnd_seen++;
        if (mode >= 3'd4) last_in = mode;
      end else mctr++;
      int_in = dead ? 1'b0 : stuck ? 1'b1 : (mctr >= 1 && mctr < 1 + width_of(mode));
    end else begin
      int_in = 1'b0;
    end
    disrun    = (mode == 3'd1) ? disrun + 1 : 0;
    prev_mode = mode;
  end

  function automatic int expect_res(input int i, input int g, input int f);
    int si, sg, sf;
    si = (i > CMAX) ? CMAX : i;
    sg = (g > CMAX) ? CMAX : g;
    sf = (f > CMAX) ? CMAX : f;
    if (si <= sg) return 0;
    if (si >= sf) return (1 << RES_W) - 1;
    return int'((longint'(si - sg) * (longint'(1) << RES_W)) / longint'(sf - sg));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic convert(input int c, output int res, output int rc, output bit got_v, output bit got_e);
    got_v = 0; got_e = 0; res = -1; rc = -1;
    @(negedge clk); start = 1; chan = 2'(c);
    @(negedge clk); start = 0;
    for (int k = 0; k < 60000 && !got_v && !got_e; k++) begin
      if (result_valid) begin got_v = 1; res = int'(result); rc = int'(result_chan); end
      if (err) got_e = 1;
      if (!got_v && !got_e) @(negedge clk);
    end
  endtask

  initial begin
    int res, rc, g0;
    bit v, e;
    repeat (3) @(negedge clk);
    chk(mode == 3'd0 && !busy && !result_valid && !err, "R1 R8 reset state", int'(mode), 0);
    rst_n = 1;
    @(negedge clk);

    // vector table, one calibration then cached
    for (int n = 0; n < NV; n++) begin
      g0 = gnd_seen;
      w_in[VEC[n][0]] = VEC[n][1];
      convert(VEC[n][0], res, rc, v, e);
      chk(v && !e, "R8 valid seen", int'(v), 1);
      chk(res == expect_res(VEC[n][1], 40, 1000), "R5 R3 result", res, expect_res(VEC[n][1], 40, 1000));
      chk(rc == VEC[n][0], "R8 result_chan", rc, VEC[n][0]);
      chk(last_in == 3'(4 + VEC[n][0]), "R1 input code", int'(last_in), 4 + VEC[n][0]);
      if (n == 0) begin
        chk(seq[0] == 3'd2 && seq[1] == 3'd3 && seq[2] == 3'd4, "R4 order", int'({seq[0], seq[1], seq[2]}), 'o234);
        chk(gnd_seen == g0 + 1, "R4 calibrated once", gnd_seen - g0, 1);
      end else chk(gnd_seen == g0, "R6 no recalibration", gnd_seen - g0, 0);
    end

    // cached pair survives changed ground and reference widths (R6)
    w_gnd = 100; w_ref = 500; w_in[1] = 300;
    g0 = gnd_seen;
    convert(1, res, rc, v, e);
    chk(res == expect_res(300, 40, 1000), "R6 cached calibration", res, expect_res(300, 40, 1000));
    chk(gnd_seen == g0, "R6 no ground selection", gnd_seen - g0, 0);

    // recalibration after recal_every conversions (R7); 9 done so far
    recal_every = 8'd10;
    convert(1, res, rc, v, e);
    chk(res == expect_res(300, 40, 1000), "R7 before limit", res, expect_res(300, 40, 1000));
    g0 = gnd_seen;
    convert(1, res, rc, v, e);
    chk(res == expect_res(300, 100, 500), "R7 new calibration", res, expect_res(300, 100, 500));
    chk(gnd_seen == g0 + 1, "R7 recalibrated", gnd_seen - g0, 1);
    recal_every = 8'd0;
    g0 = gnd_seen;
    convert(2, res, rc, v, e);
    convert(3, res, rc, v, e);
    chk(gnd_seen == g0 + 2, "R7 every request", gnd_seen - g0, 2);

    // start while busy is ignored (R10)
    w_in[2] = 400;
    @(negedge clk); start = 1; chan = 2'd2;
    @(negedge clk); start = 0;
    repeat (300) @(negedge clk);
    start = 1; chan = 2'd3;
    @(negedge clk); start = 0;
    v = 0;
    for (int k = 0; k < 20000 && !v; k++) begin
      if (result_valid) begin v = 1; res = int'(result); rc = int'(result_chan); end
      else @(negedge clk);
    end
    chk(v && rc == 2, "R10 channel kept", rc, 2);
    chk(res == expect_res(400, 100, 500), "R10 result of first request", res, expect_res(400, 100, 500));
    repeat (20) @(negedge clk);
    chk(!busy, "R10 no second conversion", int'(busy), 0);

    // timeout with no pulse (R9)
    recal_every = 8'd100; timeout_cycles = 16'd300; dead = 1;
    convert(0, res, rc, v, e);
    chk(e && !v, "R9 abort on missing pulse", int'(e), 1);
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    chk(!busy && mode == 3'd0, "R9 back to idle", int'(busy), 0);
    dead = 0; timeout_cycles = 16'd3000;
    g0 = gnd_seen; w_in[0] = 250;
    convert(0, res, rc, v, e);
    chk(gnd_seen == g0 + 1, "R9 calibration discarded", gnd_seen - g0, 1);
    chk(res == expect_res(250, 100, 500), "R9 result after abort", res, expect_res(250, 100, 500));

    // timeout with a pulse that never ends (R9)
    timeout_cycles = 16'd300; stuck = 1;
    convert(0, res, rc, v, e);
    chk(e && !v, "R9 abort on stuck pulse", int'(e), 1);
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    stuck = 0;

    // saturating reference count (R3), minimal discharge (R2)
    timeout_cycles = 16'd20000; dis_cycles = 16'd0;
    w_gnd = 40; w_ref = 17000; w_in[0] = 8211;
    convert(0, res, rc, v, e);
    chk(v && res == expect_res(8211, 40, 17000), "R3 saturation", res, expect_res(8211, 40, 17000));

    chk(dis_viol == 0, "R2 discharge hold", dis_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule